// File: doc/BRIEF.md
# Serial Adapter Status and Interrupt Controller

This block keeps the eight-bit status word of an asynchronous serial adapter and drives its active-low interrupt request. The receive and transmit engines report single-cycle events to it: a word was moved into the receive holding register (with its framing and parity flags), the receive holding register was read, the transmit holding register was written or emptied into the shifter. The two modem inputs, carrier detect and data-set-ready, are synchronised inside the block. Whenever either line changes, the new levels are frozen in the status word and an interrupt is raised.

The enable and mode fields of the command register arrive as plain level inputs. A one-cycle program-reset strobe applies the soft-reset rules. The owner of the command register is expected to clear its low five bits on the same edge. A one-cycle status-read strobe marks that the processor has taken the status word. The word presented on `status` in that cycle is the one read, and the clearing effects appear on the following edge. Every pin is a plain level or strobe with no valid/ready handshake. No transfer can be refused, so the block has no back-pressure rules. The request pin is modelled as an output-enable plus a value of zero, the way an open-drain driver behaves.

Top module: `uart_stat_irq`

## Requirements
- R1: After a hardware reset the status word reads 0x10 once the modem inputs have settled (TDRE set, every other bit clear, modem bits equal to their input levels). The request pin is released.
- R2: Status bit positions are: 7 interrupt, 6 DSR level, 5 DCD level, 4 TDRE, 3 RDRF, 2 overrun, 1 framing error, 0 parity error. Bits 6 and 5 show the active-low input level (1 = line high).
- R3: `rx_load` with RDRF clear sets RDRF and captures `rx_fe`/`rx_pe` into bits 1 and 0. `rx_rd` clears RDRF, overrun, framing and parity. A load and a read in the same cycle leave the new word accepted.
- R4: `rx_load` while RDRF is set (and no read that cycle) sets overrun and leaves RDRF, framing and parity unchanged. Overrun is cleared by `rx_rd` or by program reset, and program reset wins over a simultaneous overrun.
- R5: TDRE is 1 after reset. It is cleared by `tx_wr` and set by `tx_empty_set`. If both occur in the same cycle, TDRE ends at 0.
- R6: With `cmd_dtr`=1, a change on a synchronised modem line sets the interrupt bit and freezes bits 6 and 5 at the levels just after the change. Later changes do not alter them until a status read.
- R7: On a status read with a frozen modem state, if the present levels differ from the frozen ones, bits 6 and 5 take the new levels and the interrupt bit stays set. Otherwise the freeze is released.
- R8: Overrun, framing and parity never raise the interrupt bit.
- R9: An accepted receive word raises an interrupt only when `cmd_dtr`=1 and `cmd_ird`=0. `tx_empty_set` raises one only when `cmd_dtr`=1 and `cmd_tic`=01.
- R10: With `cmd_dtr`=0 no interrupt is raised. Bits 6 and 5 then track the synchronised inputs without freezing.
- R11: A status read clears the interrupt bit on the next edge, unless a new enabled event occurs in that same cycle.
- R12: Program reset releases an interrupt raised by a modem change, keeps one raised by a receive or transmit event, and clears overrun.
- R13: `rts_n` is high only when `cmd_tic`=00 and `cmd_echo`=0. `tx_break` is high when `cmd_tic`=11. `dtr_n` is the inverse of `cmd_dtr`.
- R14: `irq_oe` equals status bit 7, and `irq_n` is 0 whenever `irq_oe` is 1 (1 otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| prog_rst | input | 1 | Program-reset strobe |
| stat_rd | input | 1 | Status-read strobe |
| rx_load | input | 1 | Receive word ready to enter the holding register |
| rx_fe | input | 1 | Framing error of that word |
| rx_pe | input | 1 | Parity error of that word |
| rx_rd | input | 1 | Receive holding register read strobe |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_empty_set | input | 1 | Transmit holding register moved to shifter |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| cmd_dtr | input | 1 | Master ready / interrupt enable |
| cmd_ird | input | 1 | Receive interrupt disable |
| cmd_tic | input | 2 | Transmit interrupt and RTS control |
| cmd_echo | input | 1 | Echo mode select |
| status | output | 8 | Status word |
| irq_n | output | 1 | Interrupt request value (0 when driven) |
| irq_oe | output | 1 | Interrupt request drive enable |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| tx_break | output | 1 | Transmit break request |

## Verification
The hardest case is the read-time recheck. A modem line must change, and while its status is frozen, change again before the processor reads. The stimulus toggles carrier detect high and waits for the freeze. It then returns the line low and waits for the synchroniser to settle, so that the status read sees a difference from the frozen level. A second read then confirms that the interrupt finally drops. The program-reset split between modem-caused and data-caused interrupts is reached by building each kind of pending interrupt separately and then strobing program reset.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int B_IRQ    = 7;
  localparam int B_DSR    = 6;
  localparam int B_DCD    = 5;
  localparam int B_TDRE   = 4;
  localparam int B_RDRF   = 3;
  localparam int B_OVR    = 2;
  localparam int B_FE     = 1;
  localparam int B_PE     = 0;
  localparam int MDM_LINES = 2;

  typedef enum logic [1:0] {
    TIC_OFF_RTS_HI = 2'b00,
    TIC_IRQ_ON     = 2'b01,
    TIC_IRQ_OFF    = 2'b10,
    TIC_BREAK      = 2'b11
  } tic_mode_e;
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/modem_change_latch.sv
module modem_change_latch #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stat_rd,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] view,
  output logic             chg_evt
);
  logic [WIDTH-1:0] lat_q;
  logic             pend_q;
  logic             diff;

  assign diff    = (lvl != lat_q);
  assign chg_evt = en && (pend_q ? (stat_rd && diff) : diff);
  assign view    = pend_q ? lat_q : lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '1;
      pend_q <= 1'b0;
    end else if (!en) begin
      lat_q  <= lvl;
      pend_q <= 1'b0;
    end else if (!pend_q || stat_rd) begin
      lat_q  <= lvl;
      pend_q <= diff;
    end
  end

  // R6: frozen levels hold while no status read happens
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && en && !stat_rd) |=> $stable(lat_q));

  // R10: disabled latch never stays frozen
  p_no_pend_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pend_q);
endmodule

// File: rtl/rx_tx_flags.sv
module rx_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst,
  input  logic rx_load,
  input  logic rx_fe,
  input  logic rx_pe,
  input  logic rx_rd,
  input  logic tx_wr,
  input  logic tx_empty_set,
  output logic rdrf,
  output logic ovr,
  output logic fe,
  output logic pe,
  output logic tdre,
  output logic rx_acc
);
  logic full_after_rd;

  assign full_after_rd = rdrf && !rx_rd;
  assign rx_acc        = rx_load && !full_after_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdrf <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
    end else if (rx_acc) begin
      rdrf <= 1'b1;
      fe   <= rx_fe;
      pe   <= rx_pe;
    end else if (rx_rd) begin
      rdrf <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovr <= 1'b0;
    else if (prog_rst || rx_rd)          ovr <= 1'b0;
    else if (rx_load && full_after_rd)   ovr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tdre <= 1'b1;
    else if (tx_wr)        tdre <= 1'b0;
    else if (tx_empty_set) tdre <= 1'b1;
  end

  // R3: a read with no new word empties the receive side
  p_rd_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_load) |=> (!rdrf && !fe && !pe && !ovr));

  // R4: a word arriving into a full register sets overrun and keeps old flags
  p_overrun_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rdrf && !rx_rd && !prog_rst) |=> (ovr && rdrf && $stable(fe) && $stable(pe)));

  // R5: a write always leaves the transmit register full
  p_tx_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tdre);
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_rst,
  input  logic        stat_rd,
  input  logic        rx_load,
  input  logic        rx_fe,
  input  logic        rx_pe,
  input  logic        rx_rd,
  input  logic        tx_wr,
  input  logic        tx_empty_set,
  input  logic        dcd_n,
  input  logic        dsr_n,
  input  logic        cmd_dtr,
  input  logic        cmd_ird,
  input  logic [1:0]  cmd_tic,
  input  logic        cmd_echo,
  output logic [7:0]  status,
  output logic        irq_n,
  output logic        irq_oe,
  output logic        rts_n,
  output logic        dtr_n,
  output logic        tx_break
);
  localparam int L_DCD = 0;
  localparam int L_DSR = 1;

  logic [MDM_LINES-1:0] mdm_raw, mdm_sync, mdm_view;
  logic mdm_en, mdm_chg;
  logic rdrf, ovr, fe, pe, tdre, rx_acc;
  logic rx_evt, tx_evt;
  logic src_mdm_q, src_dat_q, irq;
  tic_mode_e tic;

  assign tic            = tic_mode_e'(cmd_tic);
  assign mdm_raw[L_DCD] = dcd_n;
  assign mdm_raw[L_DSR] = dsr_n;

  modem_line_sync #(.WIDTH(MDM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mdm_raw), .sync_out(mdm_sync));

  assign mdm_en = cmd_dtr && !prog_rst;

  modem_change_latch #(.WIDTH(MDM_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .en(mdm_en), .stat_rd(stat_rd),
    .lvl(mdm_sync), .view(mdm_view), .chg_evt(mdm_chg));

  rx_tx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst),
    .rx_load(rx_load), .rx_fe(rx_fe), .rx_pe(rx_pe), .rx_rd(rx_rd),
    .tx_wr(tx_wr), .tx_empty_set(tx_empty_set),
    .rdrf(rdrf), .ovr(ovr), .fe(fe), .pe(pe), .tdre(tdre), .rx_acc(rx_acc));

  assign rx_evt = rx_acc && cmd_dtr && !cmd_ird && !prog_rst;
  assign tx_evt = tx_empty_set && cmd_dtr && (tic == TIC_IRQ_ON) && !prog_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         src_mdm_q <= 1'b0;
    else if (prog_rst)  src_mdm_q <= 1'b0;
    else if (mdm_chg)   src_mdm_q <= 1'b1;
    else if (stat_rd)   src_mdm_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 src_dat_q <= 1'b0;
    else if (rx_evt || tx_evt)  src_dat_q <= 1'b1;
    else if (stat_rd)           src_dat_q <= 1'b0;
  end

  assign irq = src_mdm_q || src_dat_q;

  always_comb begin
    status         = '0;
    status[B_IRQ]  = irq;
    status[B_DSR]  = mdm_view[L_DSR];
    status[B_DCD]  = mdm_view[L_DCD];
    status[B_TDRE] = tdre;
    status[B_RDRF] = rdrf;
    status[B_OVR]  = ovr;
    status[B_FE]   = fe;
    status[B_PE]   = pe;
  end

  assign irq_oe   = irq;
  assign irq_n    = !irq;
  assign rts_n    = (tic == TIC_OFF_RTS_HI) && !cmd_echo;
  assign dtr_n    = !cmd_dtr;
  assign tx_break = (tic == TIC_BREAK);

  // R10: no interrupt can begin while the master ready bit is low
  p_irq_needs_dtr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cmd_dtr));

  // R12: program reset drops the modem interrupt source
  p_prog_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_rst |=> !src_mdm_q);

  // R11: a read with no new event clears the summary bit
  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !mdm_chg && !rx_evt && !tx_evt) |=> !irq);

  // R8: error-only activity never raises the request
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdm_chg && !rx_evt && !tx_evt && !irq) |=> !irq);
endmodule

// File: tb/test_uart_stat_irq.sv
module test_uart_stat_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_rst = 0, stat_rd = 0, rx_load = 0, rx_fe = 0, rx_pe = 0, rx_rd = 0;
  logic tx_wr = 0, tx_empty_set = 0, dcd_n = 0, dsr_n = 0;
  logic cmd_dtr = 0, cmd_ird = 0, cmd_echo = 0;
  logic [1:0] cmd_tic = 2'b00;
  logic [7:0] status;
  logic irq_n, irq_oe, rts_n, dtr_n, tx_break;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_stat_irq i_uart_stat_irq (
    .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .stat_rd(stat_rd),
    .rx_load(rx_load), .rx_fe(rx_fe), .rx_pe(rx_pe), .rx_rd(rx_rd),
    .tx_wr(tx_wr), .tx_empty_set(tx_empty_set), .dcd_n(dcd_n), .dsr_n(dsr_n),
    .cmd_dtr(cmd_dtr), .cmd_ird(cmd_ird), .cmd_tic(cmd_tic), .cmd_echo(cmd_echo),
    .status(status), .irq_n(irq_n), .irq_oe(irq_oe), .rts_n(rts_n),
    .dtr_n(dtr_n), .tx_break(tx_break));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_pin(input string req);
    chk(req, {6'b0, irq_oe, irq_n}, {6'b0, status[7], !status[7]});
  endtask

  // bench reference for the receive/transmit flags (R3, R4, R5)
  logic m_rdrf, m_ovr, m_fe, m_pe, m_tdre;
  function automatic logic [4:0] model_flags();
    return {m_tdre, m_rdrf, m_ovr, m_fe, m_pe};
  endfunction

  task automatic model_step(input logic ld, input logic fe_i, input logic pe_i,
                            input logic rd, input logic wr, input logic emp, input logic pr);
    logic full;
    full = m_rdrf && !rd;
    if (pr || rd) m_ovr = 1'b0;
    else if (ld && full) m_ovr = 1'b1;
    if (ld && !full) begin m_rdrf = 1; m_fe = fe_i; m_pe = pe_i; end
    else if (rd) begin m_rdrf = 0; m_fe = 0; m_pe = 0; end
    if (wr) m_tdre = 0; else if (emp) m_tdre = 1;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 R2 reset state with modem lines low
    chk("R1", status, 8'h10);
    chk("R14", {6'b0, irq_oe, irq_n}, 8'h01);
    chk("R13", {6'b0, dtr_n, rts_n}, 8'h03);

    // R13 command decode
    cmd_tic = 2'b01; #1; chk("R13", {5'b0, rts_n, tx_break, dtr_n}, 8'h01);
    cmd_tic = 2'b11; #1; chk("R13", {5'b0, rts_n, tx_break, dtr_n}, 8'h03);
    cmd_tic = 2'b00; cmd_echo = 1; cmd_dtr = 1; #1;
    chk("R13", {5'b0, rts_n, tx_break, dtr_n}, 8'h00);
    cmd_echo = 0;
    step();

    // R3 R9 receive word raises interrupt
    rx_load = 1; rx_fe = 1; step(); rx_load = 0; rx_fe = 0;
    chk("R3", status, 8'h9A);
    chk_pin("R14");
    stat_rd = 1; step(); stat_rd = 0;
    chk("R11", status, 8'h1A);
    // R4 R8 overrun
    rx_load = 1; rx_pe = 1; step(); rx_load = 0; rx_pe = 0;
    chk("R4", status, 8'h1E);
    chk("R8", {7'b0, irq_oe}, 8'h00);
    rx_rd = 1; step(); rx_rd = 0;
    chk("R3", status, 8'h10);

    // R5 R9 transmit side
    tx_wr = 1; step(); tx_wr = 0;
    chk("R5", status, 8'h00);
    tx_empty_set = 1; step(); tx_empty_set = 0;
    chk("R9", status, 8'h10);
    tx_wr = 1; step(); tx_wr = 0;
    cmd_tic = 2'b01;
    tx_empty_set = 1; step(); tx_empty_set = 0;
    chk("R9", status, 8'h90);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R11", status, 8'h10);
    tx_wr = 1; tx_empty_set = 1; step(); tx_wr = 0; tx_empty_set = 0;
    chk("R5", status, 8'h80);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R11", status, 8'h00);
    cmd_tic = 2'b00;

    // R9 receive interrupt disabled by ird
    cmd_ird = 1;
    rx_load = 1; step(); rx_load = 0;
    chk("R9", status, 8'h08);
    rx_rd = 1; step(); rx_rd = 0;
    cmd_ird = 0;

    // R6 R7 modem change, freeze, recheck at read
    dcd_n = 1; repeat (4) step();
    chk("R6", status, 8'hA0);
    dcd_n = 0; repeat (4) step();
    chk("R6", status, 8'hA0);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R7", status, 8'h80);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R7", status, 8'h00);

    // R12 modem interrupt released by program reset
    dsr_n = 1; repeat (4) step();
    chk("R6", status, 8'hC0);
    prog_rst = 1; cmd_dtr = 0; step(); prog_rst = 0;
    chk("R12", status, 8'h40);
    chk_pin("R14");
    dsr_n = 0; repeat (4) step();
    chk("R10", status, 8'h00);

    // R12 data interrupt kept, overrun cleared
    cmd_dtr = 1;
    rx_load = 1; step(); step(); rx_load = 0;
    chk("R4", status, 8'h8C);
    prog_rst = 1; cmd_dtr = 0; step(); prog_rst = 0;
    chk("R12", status, 8'h88);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R11", status, 8'h08);
    rx_rd = 1; step(); rx_rd = 0;

    // R10 no interrupt with dtr low
    rx_load = 1; step(); rx_load = 0;
    chk("R10", status, 8'h08);
    rx_rd = 1; step(); rx_rd = 0;
    chk("R3", status, 8'h00);

    // random phase on R3 R4 R5 with interrupts disabled
    m_rdrf = 0; m_ovr = 0; m_fe = 0; m_pe = 0; m_tdre = 0;
    for (int i = 0; i < 400; i++) begin
      logic ld, fi, pi, rd, wr, em, pr;
      ld = ($urandom % 3) == 0; fi = $urandom; pi = $urandom;
      rd = ($urandom % 4) == 0; wr = ($urandom % 4) == 0;
      em = ($urandom % 3) == 0; pr = ($urandom % 16) == 0;
      rx_load = ld; rx_fe = fi; rx_pe = pi; rx_rd = rd;
      tx_wr = wr; tx_empty_set = em; prog_rst = pr;
      step();
      model_step(ld, fi, pi, rd, wr, em, pr);
      chk("R4", {3'b0, status[4:0]}, {3'b0, model_flags()});
      chk("R8", {5'b0, status[7:5]}, 8'h00);
    end
    rx_load = 0; rx_rd = 0; tx_wr = 0; tx_empty_set = 0; prog_rst = 0;
    rx_fe = 0; rx_pe = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule